// File: doc/BRIEF.md
# Serial Character Transmitter with Sixteenth-Step Stop Interval

This block turns one parallel character into an asynchronous serial frame on a single line. It accepts a character of 5 to 8 data bits through a valid/ready handshake. It sends a low start bit, the data least significant bit first, an optional even or odd parity bit, and then a high stop interval. In normal mode every bit lasts 16 pulses of an oversampling tick, and the stop interval is set in sixteenths of a bit by a 4-bit code. The meaning of that code depends on the character length. In the alternative single-rate mode each tick is one whole bit, and the stop interval is one or two bits.

A one-deep holding slot takes the next character while the current frame, or its stop interval, is still going out. The held character's start bit waits until the full stop interval has elapsed. When clear-to-send gating is enabled for a character, the block looks at the clear-to-send input only at the moment that character is ready to start. It holds the line high until the input is asserted. Later changes to the input cannot disturb a frame that is already on the line.

Top module: `uart_stop_tx`

## Requirements
- R1: After reset, and whenever no character is held, no frame is on the line and no stop interval is running, `txd` is 1 and `in_ready` and `tx_empty` are 1.
- R2: A frame is a 0 start bit followed by the data bits, least significant bit first. `cfg_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent. In normal mode each bit lasts 16 `tick16` pulses.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` at 0 the number of ones across data and parity is even; with it at 1 that number is odd.
- R4: In normal mode with 6, 7 or 8 data bits, a stop code c from 0 to 7 gives a high stop interval of 9+c ticks.
- R5: In normal mode with 5 data bits, a stop code c from 0 to 7 gives 17+c ticks.
- R6: In normal mode with any length, a stop code c from 8 to 15 gives 17+c ticks, which is 25 to 32.
- R7: When `cfg_x1` is 1, each bit lasts one tick. Bit 3 of the stop code selects the stop interval: 0 gives 1 tick and 1 gives 2 ticks. Bits 2 to 0 have no effect.
- R8: With `cfg_cts_en` at 1, a held character does not start while `cts` is 0. During that time `txd` stays 1. The character starts once `cts` is 1.
- R9: A change on `cts` after a frame has started does not alter that frame.
- R10: With `cfg_cts_en` at 0, `cts` has no effect.
- R11: `in_ready` is 1 whenever the holding slot is free, including during a frame and its stop interval. `tx_empty` is 0 while a character is held, while a frame is being sent and while a stop interval runs.
- R12: A character held during a stop interval starts only after the whole programmed stop interval has elapsed, with no added idle ticks.
- R13: All configuration inputs are captured when a character is accepted and apply to that character's whole frame, stop interval included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Baud enable: 16 per bit in normal mode, 1 per bit in single-rate mode |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding slot free; a character is taken when valid and ready are both 1 |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop | input | 4 | Stop interval code |
| cfg_cts_en | input | 1 | Gate each character start on `cts` |
| cfg_x1 | input | 1 | Single-rate mode: one tick per bit |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | Nothing held, nothing on the line, no stop interval running |

## Verification
The bench measures the width of every high and low run on `txd` between two characters sent back to back. It covers the ends of each stop-code range for 5-bit and 8-bit characters. A design that used one stop formula for all lengths, or that added an idle tick before the held character, would show a wrong high run. It also checks the stop interval against a slower tick, and checks single-rate mode with a code whose low bits would give a long interval in normal mode.

For clear-to-send, the bench holds the input low and checks that the line stays high. It then drops the input in the middle of a frame. A design that sampled the input at every bit would corrupt the decoded character. Another test changes the configuration right after a character is accepted. A design that reads the live configuration would show the wrong stop width and the wrong frame length.

// File: rtl/uart_stop_tx.sv
module uart_stop_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [3:0] cfg_stop,
  input  logic       cfg_cts_en,
  input  logic       cfg_x1,
  input  logic       cts,
  output logic       txd,
  output logic       tx_empty
);
  localparam int FW = 10;

  logic          hold_v, h_cts_en, h_x1;
  logic [FW-1:0] h_frame;
  logic [3:0]    h_nbits;
  logic [5:0]    h_stop;

  logic          busy, x1, stop_act;
  logic [FW-1:0] sh;
  logic [3:0]    bits_left, tcnt;
  logic [5:0]    stop_ld, stop_cnt;

  logic [3:0]    ndata;
  logic [7:0]    md;
  logic          par;
  logic [FW-1:0] fr;
  logic [5:0]    stop_t;
  logic          accept, stop_done, go;

  assign ndata  = 4'd5 + {2'b00, cfg_len};
  assign md     = in_data & (8'hFF >> (4'd8 - ndata));
  assign par    = (^md) ^ cfg_par_odd;
  assign stop_t = cfg_x1 ? (cfg_stop[3] ? 6'd2 : 6'd1)
                : {2'b00, cfg_stop} + ((cfg_stop[3] || cfg_len == 2'd0) ? 6'd17 : 6'd9);

  always_comb begin
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(ndata)) fr[i+1] = md[i];
    if (cfg_par_en) fr[ndata + 4'd1] = par;
  end

  assign in_ready  = !hold_v;
  assign accept    = in_valid && in_ready;
  assign stop_done = stop_act && tick16 && stop_cnt == 6'd1;
  assign go        = hold_v && !busy && (!stop_act || stop_done) && (!h_cts_en || cts);
  assign txd       = busy ? sh[0] : 1'b1;
  assign tx_empty  = !hold_v && !busy && !stop_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      h_frame  <= '1;
      h_nbits  <= '0;
      h_stop   <= '0;
      h_cts_en <= 1'b0;
      h_x1     <= 1'b0;
    end else if (accept) begin
      hold_v   <= 1'b1;
      h_frame  <= fr;
      h_nbits  <= 4'd1 + ndata + {3'b000, cfg_par_en};
      h_stop   <= stop_t;
      h_cts_en <= cfg_cts_en;
      h_x1     <= cfg_x1;
    end else if (go) begin
      hold_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      x1        <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      stop_ld   <= '0;
      stop_act  <= 1'b0;
      stop_cnt  <= '0;
    end else begin
      if (stop_act && tick16) begin
        if (stop_cnt == 6'd1) stop_act <= 1'b0;
        else                  stop_cnt <= stop_cnt - 6'd1;
      end
      if (go) begin
        busy      <= 1'b1;
        sh        <= h_frame;
        bits_left <= h_nbits;
        tcnt      <= '0;
        x1        <= h_x1;
        stop_ld   <= h_stop;
      end else if (busy && tick16) begin
        if (x1 || tcnt == 4'd15) begin
          tcnt      <= '0;
          sh        <= {1'b1, sh[FW-1:1]};
          bits_left <= bits_left - 4'd1;
          if (bits_left == 4'd1) begin
            busy     <= 1'b0;
            stop_act <= 1'b1;
            stop_cnt <= stop_ld;
          end
        end else begin
          tcnt <= tcnt + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_stop_tx_chk.sv
module uart_stop_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       in_ready,
  input logic       in_valid,
  input logic       tx_empty,
  input logic       cts,
  input logic       go,
  input logic       h_cts_en,
  input logic       busy,
  input logic       stop_act,
  input logic [5:0] stop_cnt
);
  assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && in_ready));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && h_cts_en) |-> cts);

  assert_take_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_stop_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_act |-> (stop_cnt >= 6'd1 && stop_cnt <= 6'd32));

  assert_stop_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_act |-> (txd && !tx_empty));
endmodule

bind uart_stop_tx uart_stop_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .in_ready(in_ready), .in_valid(in_valid),
  .tx_empty(tx_empty), .cts(cts), .go(go), .h_cts_en(h_cts_en), .busy(busy),
  .stop_act(stop_act), .stop_cnt(stop_cnt)
);

// File: tb/sim_uart_stop_tx.sv
`timescale 1ns/1ps
module sim_uart_stop_tx;
  logic clk = 1'b0, rst_n = 1'b0, tick16;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_cts_en = 1'b0, cfg_x1 = 1'b0, cts = 1'b0;
  logic [3:0] cfg_stop = 4'd15;
  logic txd, tx_empty;
  int checks = 0, errors = 0;
  int div = 1, tcount = 0;
  int run = 0, last_hi = 0, last_lo = 0;
  logic prev = 1'b1;

  always #2.5 clk = ~clk;

  uart_stop_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cfg_x1(cfg_x1), .cts(cts),
    .txd(txd), .tx_empty(tx_empty)
  );

  initial tick16 = 1'b1;
  always @(negedge clk) begin
    tcount = (tcount + 1 >= div) ? 0 : tcount + 1;
    tick16 = (tcount == 0);
  end

  always @(negedge clk) begin
    if (txd === prev) run++;
    else begin
      if (prev) last_hi = run; else last_lo = run;
      run = 1;
    end
    prev = txd;
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic wait_empty();
    int n = 0;
    @(negedge clk);
    while (!tx_empty && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic recv(input int nb, input bit pe, output logic [7:0] d, output logic p);
    d = '0; p = 1'b0;
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    if (pe) begin repeat (16) @(negedge clk); p = txd; end
  endtask

  task automatic test_reset();
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(tx_empty === 1'b1, "R1 tx_empty", int'(tx_empty), 1);
  endtask

  task automatic test_frame(input logic [1:0] len, input bit pe, input bit odd,
                            input logic [7:0] d, input logic [7:0] exp_d, input logic exp_p,
                            input string req);
    logic [7:0] got; logic gp;
    cfg_len = len; cfg_par_en = pe; cfg_par_odd = odd; cfg_stop = 4'd15;
    fork
      send(d);
      recv(5 + int'(len), pe, got, gp);
    join
    chk(got === exp_d, req, int'(got), int'(exp_d));
    if (pe) chk(gp === exp_p, {req, " parity"}, int'(gp), int'(exp_p));
    wait_empty();
  endtask

  task automatic test_stop(input logic [1:0] len, input logic [3:0] code, input bit x1,
                           input int dv, input int exp_ticks, input string req);
    int bitlen;
    cfg_len = len; cfg_stop = code; cfg_x1 = x1; cfg_par_en = 1'b0; div = dv;
    bitlen = (x1 ? 1 : 16) * dv;
    send(8'h00);
    send(8'h00);
    wait_empty();
    chk(last_hi == exp_ticks * dv, {req, " stop width"}, last_hi, exp_ticks * dv);
    chk(last_lo == (6 + int'(len)) * bitlen, {req, " low run"}, last_lo, (6 + int'(len)) * bitlen);
    cfg_x1 = 1'b0; div = 1;
  endtask

  task automatic test_cts();
    logic [7:0] got; logic gp;
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd8; cfg_cts_en = 1'b1; cts = 1'b0;
    send(8'h3C);
    repeat (60) @(negedge clk);
    chk(txd === 1'b1, "R8 line held high", int'(txd), 1);
    chk(in_ready === 1'b0 && tx_empty === 1'b0, "R8 char held", int'(in_ready), 0);
    fork
      recv(8, 1'b0, got, gp);
      begin
        repeat (2) @(negedge clk); cts = 1'b1;
        repeat (40) @(negedge clk); cts = 1'b0;
        repeat (30) @(negedge clk); cts = 1'b1;
      end
    join
    chk(got === 8'h3C, "R8 R9 char after cts", int'(got), 8'h3C);
    wait_empty();
    cfg_cts_en = 1'b0; cts = 1'b0;
    test_frame(2'd3, 1'b0, 1'b0, 8'hC3, 8'hC3, 1'b0, "R10 cts ignored");
  endtask

  task automatic test_flags();
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd15;
    send(8'h00);
    chk(tx_empty === 1'b0, "R11 empty low in frame", int'(tx_empty), 0);
    while (txd) @(negedge clk);
    repeat (146) @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b1, "R11 ready in stop", int'(in_ready), 1);
    chk(tx_empty === 1'b0, "R11 empty low in stop", int'(tx_empty), 0);
    repeat (40) @(negedge clk);
    chk(tx_empty === 1'b1, "R11 empty after stop", int'(tx_empty), 1);
  endtask

  task automatic test_cfg_hold();
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd15;
    send(8'h00);
    cfg_len = 2'd0; cfg_stop = 4'd0;
    send(8'h00);
    wait_empty();
    chk(last_hi == 32, "R13 stop of first char", last_hi, 32);
    chk(last_lo == 96, "R13 frame of second char", last_lo, 96);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_frame(2'd3, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, "R2 8-bit");
    test_frame(2'd0, 1'b0, 1'b0, 8'hFF, 8'h1F, 1'b0, "R2 5-bit masked");
    test_frame(2'd2, 1'b1, 1'b0, 8'h35, 8'h35, 1'b0, "R3 even");
    test_frame(2'd2, 1'b1, 1'b1, 8'h35, 8'h35, 1'b1, "R3 odd");
    test_frame(2'd1, 1'b1, 1'b0, 8'h15, 8'h15, 1'b1, "R3 even 6-bit");
    test_stop(2'd3, 4'd0,  1'b0, 1, 9,  "R4 R12 len8 code0");
    test_stop(2'd3, 4'd7,  1'b0, 1, 16, "R4 len8 code7");
    test_stop(2'd1, 4'd3,  1'b0, 2, 12, "R4 len6 code3 slow tick");
    test_stop(2'd0, 4'd0,  1'b0, 1, 17, "R5 len5 code0");
    test_stop(2'd0, 4'd7,  1'b0, 1, 24, "R5 len5 code7");
    test_stop(2'd3, 4'd8,  1'b0, 1, 25, "R6 len8 code8");
    test_stop(2'd0, 4'd15, 1'b0, 1, 32, "R6 len5 code15");
    test_stop(2'd3, 4'd7,  1'b1, 1, 1,  "R7 x1 one stop");
    test_stop(2'd3, 4'd8,  1'b1, 1, 2,  "R7 x1 two stops");
    test_cts();
    test_flags();
    test_cfg_hold();
    report();
  end
endmodule